// File: doc/BRIEF.md
# Redundant Store Check Buffer

This block guards the memory port of a pair of redundant executions of one program. The leading copy hands each committed store (address and data) to the buffer as soon as it commits. The trailing copy later offers its own version of the same store, in the same order. The buffer compares the trailing store with the oldest buffered entry. When address and data both agree, exactly one copy of the store is offered to memory. When they disagree, a sticky fault is raised so that a recovery handler can take over. No store ever reaches memory before it has been cross-checked.

All three data paths use valid/ready handshakes. A transfer happens in a cycle where both valid and ready are high.

- Leading push: the buffer lowers `lead_ready` when it is full.
- Trailing check: `trail_ready` is high only when there is an unchecked head entry, no release is pending and no fault is set.
- Memory port: a released store stays valid and unchanged until memory accepts it. The entry leaves the buffer only in the cycle it is accepted.

Top module: `stcheck_buf`

## Requirements
- R1: A leading handshake (`lead_valid` and `lead_ready` high) appends the address and data to the buffer tail. Stores leave at the memory port in the same order they were pushed.
- R2: A trailing handshake compares the trailing address and data with the head entry. `fault_kind` bit 0 reports an address difference and bit 1 reports a data difference.
- R3: On a full match, `mem_valid` rises in the next cycle, carrying the head entry's address and data. Each matched pair yields exactly one memory transfer, and nothing unchecked is ever offered.
- R4: While `mem_valid` is high and `mem_ready` is low, the address and data hold steady. The entry is removed in the cycle `mem_ready` is high, and `trail_ready` stays low while a release is pending.
- R5: On any mismatch, `fault` rises in the next cycle and stays high. `fault_kind` holds the mismatch bits, no store is released, and `trail_ready` stays low.
- R6: `fault_clr` pulsed while `fault` is high does three things. It drops `fault` and `fault_kind` to zero in the next cycle, it empties the buffer, and it holds `lead_ready` low in that cycle. When `fault` is low, `fault_clr` has no effect.
- R7: With DEPTH entries held, `lead_ready` is low and push attempts are ignored.
- R8: With the buffer empty, `trail_ready` is low and a trailing offer is ignored.
- R9: After reset the buffer is empty:
  - `lead_ready` is 1.
  - `trail_ready`, `mem_valid` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading store offered |
| lead_ready | output | 1 | Buffer can accept a leading store |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store data |
| trail_valid | input | 1 | Trailing store offered for checking |
| trail_ready | output | 1 | Buffer will check the trailing store this cycle |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store data |
| mem_valid | output | 1 | Checked store offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | ADDR_W | Checked store address |
| mem_data | output | DATA_W | Checked store data |
| fault | output | 1 | Sticky mismatch flag |
| fault_kind | output | 2 | Bit 0 address mismatch, bit 1 data mismatch |
| fault_clr | input | 1 | Clears a fault and flushes the buffer |

## Verification
The bench fills the buffer to its limit while the trailing side is idle. A design with an off-by-one full flag would then overwrite the oldest store or refuse one slot early. It holds `mem_ready` low at random so that the head must stay unchanged across the stall; a design that dequeued at check time instead would skip or repeat stores. It injects address-only, data-only and combined corruptions, and clears each fault while leading pushes keep arriving. A design that leaked the mismatching store, lost the fault bits, or kept stale entries after the flush would drift from the reference queue. It also offers trailing stores to an empty buffer and pulses the clear with no fault set, both of which must leave every output unchanged.

// File: rtl/stcheck_pkg.sv
package stcheck_pkg;
  typedef enum logic [1:0] {
    CK_WAIT    = 2'd0,
    CK_RELEASE = 2'd1,
    CK_FAULT   = 2'd2
  } ck_state_e;

  localparam int KIND_ADDR = 0;
  localparam int KIND_DATA = 1;
endpackage

// File: rtl/stcheck_fifo.sv
module stcheck_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] fill,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  assign head  = slots[rd_ptr];
  assign fill  = count;
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/stcheck_cmp.sv
module stcheck_cmp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [ADDR_W-1:0] addr_ref,
  input  logic [ADDR_W-1:0] addr_obs,
  input  logic [DATA_W-1:0] data_ref,
  input  logic [DATA_W-1:0] data_obs,
  output logic              addr_eq,
  output logic              data_eq
);
  localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] ref_pad, obs_pad;
  logic [LANES-1:0] lane_eq;

  assign ref_pad = PAD_W'(data_ref);
  assign obs_pad = PAD_W'(data_obs);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_eq[i] = (ref_pad[i*LANE_W +: LANE_W] == obs_pad[i*LANE_W +: LANE_W]);
  end

  assign data_eq = &lane_eq;
  assign addr_eq = (addr_ref == addr_obs);
endmodule

// File: rtl/stcheck_ctrl.sv
module stcheck_ctrl
  import stcheck_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       head_valid,
  input  logic       addr_eq,
  input  logic       data_eq,
  input  logic       trail_valid,
  input  logic       mem_ready,
  input  logic       fault_clr,
  output logic       trail_ready,
  output logic       mem_valid,
  output logic       pop,
  output logic       flush,
  output logic       fault,
  output logic [1:0] fault_kind
);
  ck_state_e  state, state_nx;
  logic [1:0] kind_q, kind_nx;

  always_comb begin
    state_nx = state;
    kind_nx  = kind_q;
    case (state)
      CK_WAIT: begin
        if (trail_valid && head_valid) begin
          if (addr_eq && data_eq) begin
            state_nx = CK_RELEASE;
          end else begin
            state_nx = CK_FAULT;
            kind_nx[KIND_ADDR] = !addr_eq;
            kind_nx[KIND_DATA] = !data_eq;
          end
        end
      end
      CK_RELEASE: begin
        if (mem_ready) state_nx = CK_WAIT;
      end
      CK_FAULT: begin
        if (fault_clr) begin
          state_nx = CK_WAIT;
          kind_nx  = '0;
        end
      end
      default: begin
        state_nx = CK_WAIT;
        kind_nx  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CK_WAIT;
      kind_q <= '0;
    end else begin
      state  <= state_nx;
      kind_q <= kind_nx;
    end
  end

  assign trail_ready = (state == CK_WAIT) && head_valid;
  assign mem_valid   = (state == CK_RELEASE);
  assign pop         = mem_valid && mem_ready;
  assign fault       = (state == CK_FAULT);
  assign flush       = fault && fault_clr;
  assign fault_kind  = kind_q;
endmodule

// File: rtl/stcheck_buf.sv
module stcheck_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_valid,
  output logic              lead_ready,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [DATA_W-1:0] lead_data,
  input  logic              trail_valid,
  output logic              trail_ready,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic [DATA_W-1:0] trail_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              fault,
  output logic [1:0]        fault_kind,
  input  logic              fault_clr
);
  localparam int ENTRY_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   fill;
  logic               empty, full, push, pop, flush;
  logic               addr_eq, data_eq;
  logic [ADDR_W-1:0]  head_addr;
  logic [DATA_W-1:0]  head_data;

  assign lead_ready = !full && !flush;
  assign push       = lead_valid && lead_ready;
  assign head_addr  = head[ENTRY_W-1 -: ADDR_W];
  assign head_data  = head[DATA_W-1:0];

  stcheck_fifo #(.W(ENTRY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data({lead_addr, lead_data}),
    .pop(pop), .flush(flush), .head(head), .fill(fill), .empty(empty), .full(full)
  );

  stcheck_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) i_cmp (
    .addr_ref(head_addr), .addr_obs(trail_addr),
    .data_ref(head_data), .data_obs(trail_data),
    .addr_eq(addr_eq), .data_eq(data_eq)
  );

  stcheck_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .head_valid(!empty), .addr_eq(addr_eq), .data_eq(data_eq),
    .trail_valid(trail_valid), .mem_ready(mem_ready), .fault_clr(fault_clr),
    .trail_ready(trail_ready), .mem_valid(mem_valid), .pop(pop), .flush(flush),
    .fault(fault), .fault_kind(fault_kind)
  );

  assign mem_addr = head_addr;
  assign mem_data = head_data;
endmodule

// File: rtl/stcheck_buf_chk.sv
module stcheck_buf_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lead_valid,
  input logic              lead_ready,
  input logic              trail_valid,
  input logic              trail_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              fault,
  input logic [1:0]        fault_kind,
  input logic              fault_clr,
  input logic [CNT_W-1:0]  fill
);
  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lead_valid && lead_ready && !(mem_valid && mem_ready) |=> fill == $past(fill) + 1'b1);

  assert_kind_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fault_kind != 2'b00));

  assert_check_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trail_valid && trail_ready |=> mem_valid != fault);

  assert_release_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_no_check_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !trail_ready);

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !fault_clr |=> fault && $stable(fault_kind));

  assert_no_release_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_valid && !trail_ready);

  assert_clear_flushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault && fault_clr |=> !fault && fill == '0);

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill == CNT_W'(DEPTH) |-> !lead_ready);

  assert_no_check_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill == '0 |-> !trail_ready && !mem_valid);
endmodule

bind stcheck_buf stcheck_buf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_stcheck_buf.sv
module test_stcheck_buf;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 32;
  localparam int DW = 64;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lead_valid, lead_ready, trail_valid, trail_ready;
  logic mem_valid, mem_ready, fault, fault_clr;
  logic [AW-1:0] lead_addr, trail_addr, mem_addr;
  logic [DW-1:0] lead_data, trail_data, mem_data;
  logic [1:0] fault_kind;

  stcheck_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_stcheck_buf (
    .clk(clk), .rst_n(rst_n),
    .lead_valid(lead_valid), .lead_ready(lead_ready), .lead_addr(lead_addr), .lead_data(lead_data),
    .trail_valid(trail_valid), .trail_ready(trail_ready), .trail_addr(trail_addr), .trail_data(trail_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .fault(fault), .fault_kind(fault_kind), .fault_clr(fault_clr)
  );

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } st_t;

  st_t  mq[$];
  st_t  tq[$];
  bit   m_chk;
  logic [1:0] m_kind;
  int   n_pass = 0, n_fail = 0, seq = 0, rel_exp = 0, rel_seen = 0;
  bit   done = 0;

  bit s_lv, s_tv, s_mr, s_fc, s_garbage;
  logic [1:0] s_corrupt;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit e_lr, e_tr, e_mv, ae, de;
    @(negedge clk);
    lead_valid = s_lv;
    lead_addr  = 32'h1000 + AW'(seq) * 8;
    lead_data  = {32'(seq), ~32'(seq)};
    if (tq.size() > 0) begin
      trail_valid = s_tv;
      trail_addr  = tq[0].a ^ {{(AW-1){1'b0}}, s_corrupt[0]};
      trail_data  = tq[0].d ^ {s_corrupt[1], {(DW-1){1'b0}}};
    end else begin
      trail_valid = s_garbage;
      trail_addr  = $urandom;
      trail_data  = {$urandom, $urandom};
    end
    mem_ready = s_mr;
    fault_clr = s_fc;
    #1;
    e_lr = (mq.size() < DEPTH) && !(s_fc && m_kind != 2'b00);
    e_tr = (mq.size() > 0) && !m_chk && (m_kind == 2'b00);
    e_mv = m_chk;
    chk(lead_ready == e_lr, "R7 lead_ready", lead_ready, e_lr);
    chk(trail_ready == e_tr, "R8 trail_ready", trail_ready, e_tr);
    chk(mem_valid == e_mv, "R4 mem_valid", mem_valid, e_mv);
    chk(fault == (m_kind != 2'b00), "R5 fault", fault, m_kind != 2'b00);
    chk(fault_kind == m_kind, "R2 fault_kind", fault_kind, m_kind);
    if (e_mv) chk({mem_addr, mem_data} == mq[0], "R1 release payload", {mem_addr, mem_data}, mq[0]);
    if (mem_valid && mem_ready) rel_seen++;
    if (s_fc && m_kind != 2'b00) begin
      mq.delete(); tq.delete(); m_chk = 0; m_kind = 2'b00;
    end else begin
      if (m_chk && mem_ready) begin
        void'(mq.pop_front()); m_chk = 0; rel_exp++;
      end else if (trail_valid && e_tr) begin
        ae = (trail_addr != mq[0].a);
        de = (trail_data != mq[0].d);
        if (!ae && !de) m_chk = 1;
        else m_kind = {de, ae};
        if (tq.size() > 0) void'(tq.pop_front());
        s_corrupt = 2'b00;
      end
      if (lead_valid && e_lr) begin
        mq.push_back({lead_addr, lead_data});
        tq.push_back({lead_addr, lead_data});
        seq++;
      end
    end
  endtask

  task automatic inject(input logic [1:0] kind);
    s_lv = 1; s_tv = 1; s_mr = 1; s_fc = 0;
    for (int i = 0; i < 4; i++) step();
    s_corrupt = kind;
    for (int i = 0; i < 6; i++) step();
    chk(fault == 1'b1, "R5 fault after corrupt", fault, 1);
    chk(fault_kind == kind, "R2 kind after corrupt", fault_kind, kind);
    chk(mem_valid == 1'b0, "R5 no release on fault", mem_valid, 0);
    s_fc = 1; step(); s_fc = 0; s_lv = 0;
    step();
    chk(fault == 1'b0 && trail_ready == 1'b0 && lead_ready == 1'b1, "R6 clear empties",
        {fault, trail_ready, lead_ready}, 3'b001);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lead_valid = 0; trail_valid = 0; mem_ready = 0; fault_clr = 0;
    lead_addr = '0; lead_data = '0; trail_addr = '0; trail_data = '0;
    s_lv = 0; s_tv = 0; s_mr = 0; s_fc = 0; s_garbage = 0; s_corrupt = 2'b00;
    m_chk = 0; m_kind = 2'b00;
    repeat (3) @(negedge clk);
    #1;
    chk({lead_ready, trail_ready, mem_valid, fault} == 4'b1000, "R9 reset state",
        {lead_ready, trail_ready, mem_valid, fault}, 4'b1000);
    rst_n = 1;

    // R8 and R7: garbage offers to an empty buffer, then fill past capacity
    s_garbage = 1; s_lv = 1; s_tv = 0;
    for (int i = 0; i < 12; i++) step();
    chk(lead_ready == 1'b0, "R7 full stall", lead_ready, 0);
    s_garbage = 0;

    // R4: drain with a stalling memory port
    s_lv = 0; s_tv = 1;
    for (int i = 0; i < 60; i++) begin s_mr = ($urandom_range(0, 2) == 0); step(); end
    s_mr = 1;
    for (int i = 0; i < 10; i++) step();

    inject(2'b01);
    inject(2'b10);
    inject(2'b11);

    // R6: clear with no fault is ignored while a release is pending
    s_lv = 1; s_tv = 1; s_mr = 0;
    for (int i = 0; i < 4; i++) step();
    s_fc = 1;
    for (int i = 0; i < 3; i++) step();
    chk(mem_valid == 1'b1, "R6 clear without fault ignored", mem_valid, 1);
    s_fc = 0;

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      s_lv = ($urandom_range(0, 3) != 0);
      s_tv = ($urandom_range(0, 3) != 0);
      s_mr = ($urandom_range(0, 2) != 0);
      s_fc = (m_kind != 2'b00) && ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 199) == 0) s_corrupt = 2'($urandom_range(1, 3));
      step();
    end
    chk(rel_seen == rel_exp, "R3 one release per matched pair", rel_seen, rel_exp);

    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule